// File: doc/BRIEF.md
# Generator-Store Line Marshal Buffer

This block sits beside one core's store pipeline. It watches committed stores and keeps the cache-line address of each store that is tagged as a generator store. A generator store is one that produces data a later code segment will consume on another core. The buffer keeps only addresses, never data. Several generator stores that hit the same 64-byte line share one entry, so entries are line addresses in first-touch order.

When software issues a marshal command that names a destination core, the buffer replays every recorded line as a push request on a valid/ready output stream. Each request carries the line-aligned address and the destination core number. Downstream logic uses these requests to copy the line into that core's private cache before the next segment starts there. When the last request has been accepted, the buffer empties itself and raises a one-cycle completion pulse.

Back-pressure follows these rules:
- A push request holds its address and destination unchanged until `push_ready` is high at a clock edge.
- While a drain is in progress, both `st_ready` and `cmd_ready` stay low, so no store or command is taken.
- Outside a drain, stores are always accepted. If the buffer is full, a new line is discarded and a saturating counter records the loss; the store itself is never stalled.

Top module: `marshal_buf`

## Requirements
- R1: After reset, `push_valid` and `done` are 0, `ovf_count` is 0, and both `st_ready` and `cmd_ready` are 1.
- R2: A store accepted with `st_gen`=0 records nothing: a marshal command that follows it, with no generator store in between, issues no push request.
- R3: An accepted generator store to a line not yet recorded allocates an entry. Its push request shows the address with bits [5:0] cleared.
- R4: A generator store whose address bits [47:6] equal those of a recorded entry allocates nothing, so that line is pushed exactly once.
- R5: A drain emits one request per recorded line, in the order the lines were first recorded. Each request carries `push_dest` equal to the `cmd_dest` taken with the command.
- R6: While `push_valid` is 1 and `push_ready` is 0, the next cycle still has `push_valid` at 1 with `push_addr` and `push_dest` unchanged. At most one request is accepted per cycle.
- R7: With 16 lines recorded, a generator store to a new line is dropped. `ovf_count` rises by one, saturating, and the recorded entries are unaffected.
- R8: `done` is high for the single cycle after the last push handshake, and the buffer is empty from then on.
- R9: A marshal command accepted while the buffer is empty raises `done` in the next cycle and issues no push request.
- R10: From the cycle after a command with recorded lines is accepted until `done`, `st_ready` and `cmd_ready` are 0.
- R11: A generator store accepted in the same cycle as a marshal command is recorded and included in that drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Committed store present |
| st_ready | output | 1 | Store can be taken (low during a drain) |
| st_addr | input | 48 | Physical byte address of the store |
| st_gen | input | 1 | Store carries the generator tag |
| cmd_valid | input | 1 | Marshal command present |
| cmd_ready | output | 1 | Command can be taken (low during a drain) |
| cmd_dest | input | 6 | Destination core number |
| push_valid | output | 1 | Push request valid |
| push_ready | input | 1 | Push request accepted by downstream |
| push_addr | output | 48 | Line-aligned address to push |
| push_dest | output | 6 | Core that receives the line |
| done | output | 1 | One-cycle pulse: drain complete |
| ovf_count | output | 8 | Saturating count of dropped lines |

## Verification
Directed sequences cover four cases:
- Ordinary stores only, which must leave the buffer empty.
- Repeated stores to one line at different byte offsets, which separate merging from allocation.
- More than sixteen distinct lines, which exposes the drop-and-count path and shows the first sixteen kept in order.
- A store arriving in the same cycle as the command, which must be included in that drain.

Random rounds draw addresses from a small line pool, so merges, fresh allocations and overflow mix. They vary the share of generator-tagged stores and the destination, and drain against random back-pressure. This separates ordering and stability faults from faults that appear only under a stalled output.

// File: rtl/mb_pkg.sv
package mb_pkg;
  typedef enum logic [0:0] {
    MB_IDLE  = 1'b0,
    MB_DRAIN = 1'b1
  } mb_state_e;
endpackage

// File: rtl/mb_match.sv
module mb_match #(
  parameter int DEPTH  = 16,
  parameter int LINE_W = 42
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [DEPTH-1:0][LINE_W-1:0] lines,
  input  logic [DEPTH-1:0]             valid,
  input  logic [LINE_W-1:0]            probe,
  output logic                         hit
);
  logic [DEPTH-1:0] hit_vec;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit_vec[i] = valid[i] && (lines[i] == probe);
  end

  assign hit = |hit_vec;

  // R4: merging keeps entries unique, so at most one entry can match
  a_r4_unique_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: rtl/mb_store.sv
module mb_store #(
  parameter int DEPTH  = 16,
  parameter int LINE_W = 42,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = IDX_W + 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [LINE_W-1:0]            wr_line,
  input  logic                         clr,
  output logic [DEPTH-1:0][LINE_W-1:0] lines,
  output logic [DEPTH-1:0]             valid,
  output logic [CW-1:0]                count,
  output logic                         full
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (wr_en) begin
      count <= count + 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lines[i] <= '0;
      end else if (wr_en && !clr && (count == CW'(i))) begin
        lines[i] <= wr_line;
      end
    end
    assign valid[i] = (count > CW'(i));
  end

  assign full = (count == CW'(DEPTH));

  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r7_no_write_full: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);
endmodule

// File: rtl/mb_drain.sv
module mb_drain #(
  parameter int DEPTH  = 16,
  parameter int LINE_W = 42,
  parameter int CORE_W = 6,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = IDX_W + 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_fire,
  input  logic [CORE_W-1:0]            cmd_dest,
  input  logic                         alloc_now,
  input  logic [CW-1:0]                count,
  input  logic [DEPTH-1:0][LINE_W-1:0] lines,
  output logic                         busy,
  output logic                         push_valid,
  input  logic                         push_ready,
  output logic [LINE_W-1:0]            push_line,
  output logic [CORE_W-1:0]            push_dest,
  output logic                         clr,
  output logic                         done
);
  import mb_pkg::*;

  mb_state_e          state;
  logic [IDX_W-1:0]   rd_idx;
  logic [CORE_W-1:0]  dest_q;
  logic               last;

  assign busy       = (state == MB_DRAIN);
  assign push_valid = busy;
  assign push_line  = lines[rd_idx];
  assign push_dest  = dest_q;
  assign last       = ({1'b0, rd_idx} == (count - 1'b1));
  assign clr        = busy && push_ready && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= MB_IDLE;
      rd_idx <= '0;
      dest_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        MB_IDLE: begin
          if (cmd_fire) begin
            dest_q <= cmd_dest;
            rd_idx <= '0;
            if ((count == '0) && !alloc_now) begin
              done <= 1'b1;
            end else begin
              state <= MB_DRAIN;
            end
          end
        end
        MB_DRAIN: begin
          if (push_ready) begin
            if (last) begin
              state <= MB_IDLE;
              done  <= 1'b1;
            end else begin
              rd_idx <= rd_idx + 1'b1;
            end
          end
        end
        default: state <= MB_IDLE;
      endcase
    end
  end

  // R6: a stalled request holds its content
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready) |=>
      (push_valid && $stable(push_line) && $stable(push_dest)));
  // R5: a drain never starts with nothing to emit
  a_r5_nonempty_drain: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> (count != '0));
endmodule

// File: rtl/marshal_buf.sv
module marshal_buf #(
  parameter int ADDR_W     = 48,
  parameter int LINE_BYTES = 64,
  parameter int DEPTH      = 16,
  parameter int CORE_W     = 6,
  parameter int OVF_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              st_gen,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CORE_W-1:0] cmd_dest,
  output logic              push_valid,
  input  logic              push_ready,
  output logic [ADDR_W-1:0] push_addr,
  output logic [CORE_W-1:0] push_dest,
  output logic              done,
  output logic [OVF_W-1:0]  ovf_count
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW     = IDX_W + 1;

  logic [DEPTH-1:0][LINE_W-1:0] lines;
  logic [DEPTH-1:0]             valid;
  logic [CW-1:0]                count;
  logic                         full, hit, busy, clr;
  logic                         st_fire, gen_fire, alloc, drop, cmd_fire;
  logic [LINE_W-1:0]            probe, push_line;
  logic                         unused_offset;

  assign probe         = st_addr[ADDR_W-1:OFF_W];
  assign unused_offset = ^st_addr[OFF_W-1:0];

  assign st_ready  = !busy;
  assign cmd_ready = !busy;
  assign st_fire   = st_valid && st_ready;
  assign gen_fire  = st_fire && st_gen;
  assign alloc     = gen_fire && !hit && !full;
  assign drop      = gen_fire && !hit && full;
  assign cmd_fire  = cmd_valid && cmd_ready;

  mb_match #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_match (
    .clk(clk), .rst_n(rst_n), .lines(lines), .valid(valid),
    .probe(probe), .hit(hit)
  );

  mb_store #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(alloc), .wr_line(probe), .clr(clr),
    .lines(lines), .valid(valid), .count(count), .full(full)
  );

  mb_drain #(.DEPTH(DEPTH), .LINE_W(LINE_W), .CORE_W(CORE_W)) u_drain (
    .clk(clk), .rst_n(rst_n), .cmd_fire(cmd_fire), .cmd_dest(cmd_dest),
    .alloc_now(alloc), .count(count), .lines(lines), .busy(busy),
    .push_valid(push_valid), .push_ready(push_ready), .push_line(push_line),
    .push_dest(push_dest), .clr(clr), .done(done)
  );

  assign push_addr = {push_line, {OFF_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_count <= '0;
    end else if (drop && (ovf_count != '1)) begin
      ovf_count <= ovf_count + 1'b1;
    end
  end

  // R7: the loss counter moves only when the buffer was full
  a_r7_ovf_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_count != $past(ovf_count)) |-> $past(full));
  // R10: no store or command is taken while requests are outstanding
  a_r10_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> (!st_ready && !cmd_ready));
  // R8: completion leaves the buffer empty and the stream idle
  a_r8_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((count == '0) && !push_valid));
  // R9: a drain cannot start and complete in the command cycle
  a_r9_done_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(push_valid) |-> !done);
endmodule

// File: tb/marshal_buf_bench.sv
`timescale 1ns/1ps
module marshal_buf_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_valid = 1'b0, st_gen = 1'b0;
  logic [47:0] st_addr = '0;
  logic        cmd_valid = 1'b0;
  logic [5:0]  cmd_dest = '0;
  logic        push_ready = 1'b0;
  logic        st_ready, cmd_ready, push_valid, done;
  logic [47:0] push_addr;
  logic [5:0]  push_dest;
  logic [7:0]  ovf_count;

  int total = 0;
  int bad = 0;
  logic [41:0] bq[$];
  int ovf_exp = 0;

  always #2.5 clk = ~clk;

  marshal_buf u_marshal_buf (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_gen(st_gen), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_dest(cmd_dest), .push_valid(push_valid),
    .push_ready(push_ready), .push_addr(push_addr), .push_dest(push_dest),
    .done(done), .ovf_count(ovf_count)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model_store(input logic [47:0] a, input bit g);
    logic [41:0] ln = a[47:6];
    bit found = 0;
    if (!g) return;
    foreach (bq[i]) if (bq[i] == ln) found = 1;
    if (found) return;
    if (bq.size() < 16) bq.push_back(ln);
    else if (ovf_exp < 255) ovf_exp++;
  endfunction

  task automatic do_store(input logic [47:0] a, input bit g);
    st_valid = 1'b1; st_addr = a; st_gen = g;
    @(posedge clk); #1;
    st_valid = 1'b0; st_gen = 1'b0;
    model_store(a, g);
  endtask

  task automatic run_drain(input logic [5:0] dest, input int pct);
    int got = 0;
    bit seen = 0, stall = 0, blk_ok = 1, order_ok = 1;
    logic [47:0] held_a = '0;
    logic [5:0]  held_d = '0;
    for (int cyc = 0; cyc < 400 && !seen; cyc++) begin
      push_ready = ($urandom_range(99) < pct);
      @(negedge clk);
      if (done) begin
        seen = 1;
        check(got == bq.size(), "R8/R9 push count at done", got, bq.size());
        check(!push_valid, "R8 stream idle at done", push_valid, 0);
      end else if (push_valid) begin
        if (st_ready || cmd_ready) blk_ok = 0;
        if (stall)
          check(push_addr == held_a && push_dest == held_d, "R6 held request",
                push_addr, held_a);
        if (push_ready) begin
          if (got >= bq.size()) order_ok = 0;
          else begin
            check(push_addr == {bq[got], 6'b0}, "R3/R5 push address order",
                  push_addr, {bq[got], 6'b0});
            check(push_dest == dest, "R5 push destination", push_dest, dest);
          end
          got++;
          stall = 0;
        end else begin
          stall = 1; held_a = push_addr; held_d = push_dest;
        end
      end else begin
        order_ok = 0;
      end
      @(posedge clk); #1;
    end
    push_ready = 1'b0;
    check(seen, "R8 done pulse seen", seen, 1);
    check(blk_ok, "R10 ready low during drain", blk_ok, 1);
    check(order_ok, "R5 no gap or extra push", order_ok, 1);
    check(ovf_count == 8'(ovf_exp), "R7 overflow count", ovf_count, ovf_exp);
    bq.delete();
  endtask

  task automatic do_marshal(input logic [5:0] dest, input int pct);
    cmd_valid = 1'b1; cmd_dest = dest;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    run_drain(dest, pct);
  endtask

  function automatic logic [47:0] pool_addr(input int ln);
    return {30'h2A5C1, 12'(ln), 6'($urandom_range(63))};
  endfunction

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h1D5EED));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!push_valid && !done, "R1 stream idle after reset", push_valid, 0);
    check(ovf_count == 0, "R1 overflow count zero", ovf_count, 0);
    check(st_ready && cmd_ready, "R1 ready high", {st_ready, cmd_ready}, 3);
    @(posedge clk); #1;

    // R2 / R9: plain stores leave nothing behind
    for (int i = 0; i < 5; i++) do_store(pool_addr(i), 1'b0);
    do_marshal(6'd3, 100);
    // R9: empty command straight away
    do_marshal(6'd9, 100);

    // R4: repeated line at other offsets merges
    do_store({30'h2A5C1, 12'd7, 6'd0}, 1'b1);
    do_store({30'h2A5C1, 12'd7, 6'd40}, 1'b1);
    do_store({30'h2A5C1, 12'd9, 6'd63}, 1'b1);
    do_store({30'h2A5C1, 12'd7, 6'd8}, 1'b1);
    check(bq.size() == 2, "R4 model line count", bq.size(), 2);
    do_marshal(6'd17, 100);

    // R7: overfill, then drain under back-pressure (R6)
    for (int i = 0; i < 18; i++) do_store(pool_addr(100 + i), 1'b1);
    do_marshal(6'd42, 40);
    // R8: buffer empty after completion
    do_marshal(6'd1, 100);

    // R11: store and command in the same cycle
    do_store(pool_addr(300), 1'b1);
    st_valid = 1'b1; st_gen = 1'b1; st_addr = pool_addr(301);
    cmd_valid = 1'b1; cmd_dest = 6'd63;
    @(posedge clk); #1;
    st_valid = 1'b0; st_gen = 1'b0; cmd_valid = 1'b0;
    model_store(pool_addr(301), 1'b1);
    run_drain(6'd63, 70);

    // R11 into an empty buffer: must drain one line, not finish at once
    st_valid = 1'b1; st_gen = 1'b1; st_addr = pool_addr(5);
    cmd_valid = 1'b1; cmd_dest = 6'd12;
    @(posedge clk); #1;
    st_valid = 1'b0; st_gen = 1'b0; cmd_valid = 1'b0;
    model_store(pool_addr(5), 1'b1);
    run_drain(6'd12, 100);

    // random rounds
    for (int r = 0; r < 40; r++) begin
      int n = $urandom_range(26);
      int gp = $urandom_range(30, 100);
      for (int k = 0; k < n; k++)
        do_store(pool_addr($urandom_range(23)), ($urandom_range(99) < gp));
      do_marshal(6'($urandom_range(63)), $urandom_range(20, 100));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule